// File: doc/BRIEF.md
# Multi-rate parallel TDM frame timer

This block supplies byte-channel timing for an 8-bit parallel time-division port. One counter follows the receive frame pulse and numbers the channels of each receive frame. A second counter numbers the transmit channels and drives the transmit frame pulse. Each frame holds 2048, 2430 or 810 byte channels. A 2-bit code picks the length, and a new code is applied only when the current frame ends.

If the receive pulse stops arriving, the receive counter keeps wrapping at the expected count and a lost-frame flag comes on. When a pulse appears again, even in the middle of a frame, the counter returns to zero at once. The transmit frame pin can work two ways. As an output, the block drives it with selectable polarity and a selectable launch edge. As an input, an external pulse sets the transmit framing, so several devices can share one transmit frame. Data buffering and switching live outside this block.

Top module: `tdm_frame_timer`

## Requirements
- R1: The rate code sets the frame length N: 2'b00 gives 2048 channels, 2'b01 gives 2430, 2'b10 gives 810, and the spare code 2'b11 gives 2048.
- R2: On each rising clock edge without a receive pulse, `rx_chan` moves from c to c+1, and from N-1 back to 0. `rx_sof` is high exactly while `rx_chan` is 0.
- R3: With no receive pulses at all, the receive counter runs freely and keeps wrapping every N cycles.
- R4: A high `rx_fp` sampled at a rising edge makes `rx_chan` 0 after that edge, whatever the count was.
- R5: A new rate code takes effect only when a counter next returns to 0, either by a natural wrap or by a sync pulse. Until then the current frame keeps its old length.
- R6: `frame_lost` is set at the edge where the receive counter wraps with no pulse present. It is cleared at an edge where `rx_fp` is high, and it is 0 after reset.
- R7: In output mode, `tx_fp_out` equals (`tx_chan`==0) XOR `tx_fp_pol`, so `tx_fp_pol`=1 gives an active-low pulse. With `tx_launch_neg`=0 the pin changes on the rising edge. With `tx_launch_neg`=1 it changes half a cycle later, on the falling edge.
- R8: With `tx_fp_slave`=1, `tx_fp_oe` is 0 and `tx_fp_out` rests at its inactive level, which equals `tx_fp_pol`. In this mode the transmit counter is reset by `tx_fp_in` being active, meaning `tx_fp_in` XOR `tx_fp_pol` is 1. With `tx_fp_slave`=0, `tx_fp_oe` is 1 and the transmit counter is synced by `rx_fp`.
- R9: Reset is asynchronous and active low, and its release passes through two flops. While the block is held in reset, both channel counters read 0, the rate is 2048 and `frame_lost` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Frame length code |
| rx_fp | input | 1 | Receive frame pulse, active high |
| tx_fp_pol | input | 1 | Transmit pulse polarity, 1 = active low |
| tx_launch_neg | input | 1 | Launch the transmit pulse on the falling edge |
| tx_fp_slave | input | 1 | Transmit frame pin acts as an input |
| tx_fp_in | input | 1 | Transmit frame pulse from the pin |
| tx_fp_out | output | 1 | Transmit frame pulse to the pin |
| tx_fp_oe | output | 1 | Output enable of the transmit frame pin |
| rx_chan | output | 12 | Receive channel number |
| rx_sof | output | 1 | Receive channel 0 strobe |
| tx_chan | output | 12 | Transmit channel number |
| tx_sof | output | 1 | Transmit channel 0 strobe |
| frame_lost | output | 1 | Receive frame pulse missing |

## Verification
The assertions check, on every cycle, the following rules:
- each receive step is either an increment or a return to zero, and the count stays under the largest frame length;
- a receive pulse always zeroes the counter and clears the lost flag;
- the lost flag rises only at channel 0;
- in input mode the transmit pin is released, and on a rising-edge launch its level follows the transmit channel.

Other behaviours are visible only over whole scenarios, and only the bench can show them:
- the exact frame lengths for each rate code, including the spare code;
- a rate change held back until the frame boundary;
- the half-cycle delay of falling-edge launch;
- external transmit framing in input mode.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;
  typedef enum logic [1:0] {
    RATE_STD  = 2'b00,
    RATE_HIGH = 2'b01,
    RATE_LOW  = 2'b10,
    RATE_ALT  = 2'b11
  } rate_e;
endpackage

// File: rtl/tdm_chan_counter.sv
module tdm_chan_counter
  import tdm_timing_pkg::*;
#(
  parameter int CH_W   = 12,
  parameter int N_STD  = 2048,
  parameter int N_HIGH = 2430,
  parameter int N_LOW  = 810
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      rate_sel,
  input  logic            sync,
  output logic [CH_W-1:0] chan,
  output logic            free_wrap,
  output logic            start_next
);
  function automatic logic [CH_W-1:0] last_of(input logic [1:0] code);
    case (rate_e'(code))
      RATE_HIGH: return CH_W'(N_HIGH - 1);
      RATE_LOW:  return CH_W'(N_LOW - 1);
      default:   return CH_W'(N_STD - 1);
    endcase
  endfunction

  logic [CH_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0] last_q, last_d;

  always_comb begin
    free_wrap = !sync && (cnt_q == last_q);
    if (sync || (cnt_q == last_q)) cnt_d = '0;
    else                           cnt_d = cnt_q + CH_W'(1);
    start_next = (cnt_d == '0);
    last_d = start_next ? last_of(rate_sel) : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= CH_W'(N_STD - 1);
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign chan = cnt_q;
endmodule

// File: rtl/tdm_lost_flag.sv
module tdm_lost_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sync,
  input  logic free_wrap,
  output logic lost
);
  logic lost_q, lost_d;

  always_comb begin
    lost_d = lost_q;
    if (sync)           lost_d = 1'b0;
    else if (free_wrap) lost_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_q <= 1'b0;
    else        lost_q <= lost_d;
  end

  assign lost = lost_q;
endmodule

// File: rtl/tdm_tx_pulse.sv
module tdm_tx_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic start_next,
  input  logic launch_neg,
  input  logic pol,
  input  logic slave,
  output logic fp_out,
  output logic fp_oe
);
  logic rise_q;
  logic fall_q;
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b1;
    else        rise_q <= start_next;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b1;
    else        fall_q <= rise_q;
  end

  always_comb begin
    active = launch_neg ? fall_q : rise_q;
    fp_oe  = !slave;
    fp_out = slave ? pol : (active ^ pol);
  end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int CH_W   = 12,
  parameter int N_STD  = 2048,
  parameter int N_HIGH = 2430,
  parameter int N_LOW  = 810
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      rate_sel,
  input  logic            rx_fp,
  input  logic            tx_fp_pol,
  input  logic            tx_launch_neg,
  input  logic            tx_fp_slave,
  input  logic            tx_fp_in,
  output logic            tx_fp_out,
  output logic            tx_fp_oe,
  output logic [CH_W-1:0] rx_chan,
  output logic            rx_sof,
  output logic [CH_W-1:0] tx_chan,
  output logic            tx_sof,
  output logic            frame_lost
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       rx_wrap;
  logic       rx_start_unused;
  logic       tx_wrap_unused;
  logic       tx_start;
  logic       tx_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign tx_sync = tx_fp_slave ? (tx_fp_in ^ tx_fp_pol) : rx_fp;

  tdm_chan_counter #(
    .CH_W(CH_W), .N_STD(N_STD), .N_HIGH(N_HIGH), .N_LOW(N_LOW)
  ) u_rx_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rate_sel  (rate_sel),
    .sync      (rx_fp),
    .chan      (rx_chan),
    .free_wrap (rx_wrap),
    .start_next(rx_start_unused)
  );

  tdm_chan_counter #(
    .CH_W(CH_W), .N_STD(N_STD), .N_HIGH(N_HIGH), .N_LOW(N_LOW)
  ) u_tx_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rate_sel  (rate_sel),
    .sync      (tx_sync),
    .chan      (tx_chan),
    .free_wrap (tx_wrap_unused),
    .start_next(tx_start)
  );

  tdm_lost_flag u_lost (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sync     (rx_fp),
    .free_wrap(rx_wrap),
    .lost     (frame_lost)
  );

  tdm_tx_pulse u_txp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_next(tx_start),
    .launch_neg(tx_launch_neg),
    .pol       (tx_fp_pol),
    .slave     (tx_fp_slave),
    .fp_out    (tx_fp_out),
    .fp_oe     (tx_fp_oe)
  );

  assign rx_sof = (rx_chan == '0);
  assign tx_sof = (tx_chan == '0);
endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
  parameter int CH_W   = 12,
  parameter int MAX_CH = 2430
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      rate_sel,
  input logic            rx_fp,
  input logic            tx_fp_pol,
  input logic            tx_launch_neg,
  input logic            tx_fp_slave,
  input logic            tx_fp_in,
  input logic            tx_fp_out,
  input logic            tx_fp_oe,
  input logic [CH_W-1:0] rx_chan,
  input logic            rx_sof,
  input logic [CH_W-1:0] tx_chan,
  input logic            tx_sof,
  input logic            frame_lost
);
  AST_RX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rx_chan < CH_W'(MAX_CH)); // R1
  AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n) !rx_fp |=> (rx_chan == $past(rx_chan) + CH_W'(1)) || (rx_chan == '0)); // R2
  AST_RX_RESYNC: assert property (@(posedge clk) disable iff (!rst_n) rx_fp |=> rx_chan == '0); // R4
  AST_LOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rx_fp |=> !frame_lost); // R6
  AST_LOST_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(frame_lost) |-> rx_sof); // R6
  AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!tx_fp_slave && !tx_launch_neg) |-> tx_fp_out == (tx_sof ^ tx_fp_pol)); // R7
  AST_TX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) tx_fp_slave |-> (!tx_fp_oe && tx_fp_out == tx_fp_pol)); // R8
endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(.CH_W(CH_W), .MAX_CH(N_HIGH)) i_chk (.*);

// File: tb/test_tdm_frame_timer.sv
module test_tdm_frame_timer;
  localparam int CH_W = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      rate_sel = 2'b00;
  logic            rx_fp = 1'b0;
  logic            tx_fp_pol = 1'b0;
  logic            tx_launch_neg = 1'b0;
  logic            tx_fp_slave = 1'b0;
  logic            tx_fp_in = 1'b0;
  logic            tx_fp_out, tx_fp_oe, rx_sof, tx_sof, frame_lost;
  logic [CH_W-1:0] rx_chan, tx_chan;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_rx, m_tx, m_rlen, m_tlen;
  bit m_lost, e_cur, e_prev;

  always #5 clk = ~clk;

  tdm_frame_timer i_tdm_frame_timer (.*);

  function automatic int len_of(input logic [1:0] c);
    case (c)
      2'b01:   return 2430;
      2'b10:   return 810;
      default: return 2048;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    bit tsync;
    int nrx, ntx;
    @(posedge clk);
    tsync = tx_fp_slave ? (tx_fp_in ^ tx_fp_pol) : rx_fp;
    nrx = (rx_fp || m_rx == m_rlen - 1) ? 0 : m_rx + 1;
    if (rx_fp) m_lost = 1'b0;
    else if (m_rx == m_rlen - 1) m_lost = 1'b1;
    if (nrx == 0) m_rlen = len_of(rate_sel);
    m_rx = nrx;
    ntx = (tsync || m_tx == m_tlen - 1) ? 0 : m_tx + 1;
    if (ntx == 0) m_tlen = len_of(rate_sel);
    m_tx = ntx;
    e_prev = e_cur;
    e_cur = (m_tx == 0);
    #2;
    if (!tx_fp_slave)
      chk(tx_fp_out === ((tx_launch_neg ? e_prev : e_cur) ^ tx_fp_pol), "R7 launch edge",
          int'(tx_fp_out), int'((tx_launch_neg ? e_prev : e_cur) ^ tx_fp_pol));
    #6;
    chk(rx_chan == CH_W'(m_rx), "R2 rx_chan", int'(rx_chan), m_rx);
    chk(rx_sof === (m_rx == 0), "R2 rx_sof", int'(rx_sof), int'(m_rx == 0));
    chk(frame_lost === m_lost, "R6 frame_lost", int'(frame_lost), int'(m_lost));
    chk(tx_chan == CH_W'(m_tx), "R8 tx_chan", int'(tx_chan), m_tx);
    chk(tx_fp_oe === !tx_fp_slave, "R8 tx_fp_oe", int'(tx_fp_oe), int'(!tx_fp_slave));
    chk(tx_fp_out === (tx_fp_slave ? tx_fp_pol : (e_cur ^ tx_fp_pol)), "R7 tx_fp_out level",
        int'(tx_fp_out), int'(tx_fp_slave ? tx_fp_pol : (e_cur ^ tx_fp_pol)));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic to_boundary();
    for (int i = 0; i < 3000; i++) begin
      step();
      if (m_rx == 0) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx_fp = 1'b0; tx_fp_in = 1'b0; tx_fp_slave = 1'b0;
    @(posedge clk); #8;
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); #8;
    m_rx = 0; m_tx = 0; m_rlen = 2048; m_tlen = 2048;
    m_lost = 1'b0; e_cur = 1'b1; e_prev = 1'b1;
    chk(rx_chan == '0, "R9 reset rx_chan", int'(rx_chan), 0);
    chk(tx_chan == '0, "R9 reset tx_chan", int'(tx_chan), 0);
    chk(frame_lost === 1'b0, "R9 reset frame_lost", int'(frame_lost), 0);
    chk(tx_fp_oe === 1'b1, "R9 reset tx_fp_oe", int'(tx_fp_oe), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(posedge clk); #8;
    do_reset();

    // R3 free run at 2048 and R6 lost flag
    steps(2047);
    chk(rx_chan == 12'd2047, "R1 last channel at 2048", int'(rx_chan), 2047);
    step();
    chk(rx_chan == '0 && frame_lost, "R3 free-run wrap sets lost", int'(frame_lost), 1);

    // R4 mid-count resync
    steps(100);
    rx_fp = 1'b1; step(); rx_fp = 1'b0;
    chk(rx_chan == '0, "R4 mid-frame resync", int'(rx_chan), 0);
    chk(frame_lost === 1'b0, "R6 pulse clears lost", int'(frame_lost), 0);

    // R5 rate change deferred
    steps(5);
    rate_sel = 2'b10;
    steps(900);
    chk(rx_chan == 12'd905, "R5 old length held", int'(rx_chan), 905);
    to_boundary();
    steps(809);
    chk(rx_chan == 12'd809, "R1 810 last channel", int'(rx_chan), 809);
    step();
    chk(rx_chan == '0, "R1 810 wrap", int'(rx_chan), 0);

    rate_sel = 2'b01;
    to_boundary();
    steps(2429);
    chk(rx_chan == 12'd2429, "R1 2430 last channel", int'(rx_chan), 2429);
    step();
    chk(rx_chan == '0, "R1 2430 wrap", int'(rx_chan), 0);

    rate_sel = 2'b11;
    to_boundary();
    steps(2048);
    chk(rx_chan == '0, "R1 spare code gives 2048", int'(rx_chan), 0);

    // R7 polarity and launch edge
    rate_sel = 2'b10;
    tx_fp_pol = 1'b1; tx_launch_neg = 1'b1;
    to_boundary();
    steps(20);
    tx_fp_pol = 1'b0;
    to_boundary();
    steps(3);

    // R8 external transmit framing
    tx_fp_slave = 1'b1;
    tx_fp_pol = 1'b1;
    steps(50);
    tx_fp_in = 1'b0; step(); tx_fp_in = 1'b1;
    chk(tx_chan == '0, "R8 external pulse resyncs tx", int'(tx_chan), 0);
    chk(rx_chan != '0, "R8 rx unaffected by tx pulse", int'(rx_chan), m_rx);
    steps(30);
    tx_fp_slave = 1'b0;
    steps(5);

    // random mix
    for (int seg = 0; seg < 16; seg++) begin
      int gap;
      tx_fp_pol     = $urandom % 2;
      tx_launch_neg = $urandom % 2;
      tx_fp_slave   = $urandom % 2;
      tx_fp_in      = tx_fp_pol;
      gap = 700 + ($urandom % 1800);
      for (int i = 0; i < 1200; i++) begin
        if ($urandom % 400 == 0) rate_sel = $urandom % 4;
        rx_fp = ((i % gap) == gap - 1) || ($urandom % 1500 == 0);
        tx_fp_in = tx_fp_pol ^ ($urandom % 700 == 0);
        step();
      end
      rx_fp = 1'b0;
      tx_fp_in = tx_fp_pol;
    end

    do_reset();
    steps(10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule